// File: doc/BRIEF.md
# Serial Burst Register Front End

This block is the SPI slave front end of a peripheral. The serial clock is its only clock, and chip select is active low. Every transaction starts with one command byte. Bit 7 of the command byte is the write flag (1 = write, 0 = read), and bits 4:0 give the first register address. Each byte after the command reads the register that the pointer addresses; it also writes that register when the write flag is set. The pointer then moves to the next register and wraps back to the start of the bank. The transaction carries on until chip select is released.

The bank holds 22 byte-wide registers at addresses 0 to 21:

| Address | Register |
|---|---|
| 0 | control |
| 1 | polynomial |
| 2 | seed |
| 3 | length |
| 4 | spread control |
| 5 | data-low |
| 6 | data-high |
| 7 to 21 | general read/write |

Three strobes go to neighbouring logic:

- An abort request, raised when a configuration register is written.
- A transmit FIFO push, raised when the data-low register is written. The written byte comes out alongside it.
- A receive FIFO pop, raised when the data-low register is accessed while the receive FIFO reports data.

Top module: `spi_burst_regs`

## Requirements
- R1: While reset (active low) is asserted, or while chip select is high, the machine is idle and the read-data output is 0. Reset clears all 22 registers to 0 and drives all strobes low. One rising edge after chip select is released, every strobe is low.
- R2: Command bit 7 selects the access type (1 = write, 0 = read). A read burst leaves every register unchanged.
- R3: Command bits 4:0 load the register pointer. The first burst byte accesses that address.
- R4: After each complete burst byte, the pointer goes up by one. From 21 or any higher value, it goes to 0.
- R5: In a write burst, each completed byte is stored in the addressed register. The byte shifted out during that same byte is the register's content from before the write.
- R6: Completing a write byte at address 0 to 4 raises the abort request for exactly one serial clock period, starting at the byte's last rising edge.
- R7: Completing a write byte at address 5 raises the transmit push for exactly one period. The transmit data output carries the written byte.
- R8: Completing any byte at address 5 while the receive-nonempty input is high raises the receive pop for one period. When that input is low, no pop is raised.
- R9: Read data leaves most significant bit first. It changes only on falling serial clock edges.
- R10: If chip select is released part way through a byte, the partial byte is discarded: no register is written and no strobe is raised.
- R11: A pointer at address 22 to 31 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock. Data is sampled on the rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the master |
| rx_fifo_nonempty | input | 1 | The receive FIFO holds at least one entry |
| miso | output | 1 | Serial data to the master |
| abort_req | output | 1 | Abort strobe, raised on a configuration write |
| tx_fifo_push | output | 1 | Transmit FIFO push strobe |
| tx_fifo_data | output | 8 | Byte written to the data-low register |
| rx_fifo_pop | output | 1 | Receive FIFO pop strobe |

## Verification
The hardest case is a burst that runs past the end of the bank and continues at address 0. In that burst, the configuration writes that raise an abort arrive only after the wrap. A 20-byte write burst starting at address 7 produces this case, and a 25-byte read burst starting at address 3 then reads back every register across the wrap. Chip select released four bits into a byte aimed at the data-low register tests the discard path. A command that starts at address 25 tests the addresses beyond the bank and their jump back to 0.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned ADDR_W     = 5;
    localparam int unsigned NUM_REGS   = 22;
    localparam int unsigned ADDR_CFG_HI = 4;   // addresses 0..4 are configuration
    localparam int unsigned ADDR_DLO   = 5;    // data-low register

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_BURST = 2'd2
    } spi_state_e;

endpackage

// File: rtl/spi_burst_fsm.sv
module spi_burst_fsm
    import spi_burst_pkg::*;
#(
    parameter int unsigned P_DATA_W   = DATA_W,
    parameter int unsigned P_ADDR_W   = ADDR_W,
    parameter int unsigned P_NUM_REGS = NUM_REGS
) (
    input  logic                sclk,
    input  logic                arst_n,
    input  logic                mosi,
    input  logic [P_DATA_W-1:0] rd_data_i,
    output logic [P_ADDR_W-1:0] rd_addr_o,
    output logic                miso_o,
    output logic                byte_done_o,
    output logic [P_DATA_W-1:0] byte_o,
    output logic                wr_o,
    output logic [P_ADDR_W-1:0] ptr_o
);

    localparam int unsigned CNT_W = $clog2(P_DATA_W);
    localparam logic [CNT_W-1:0]    CNT_TOP  = CNT_W'(P_DATA_W - 1);
    localparam logic [P_ADDR_W-1:0] PTR_LAST = P_ADDR_W'(P_NUM_REGS - 1);

    typedef struct packed {
        spi_state_e          state;
        logic                wr;
        logic [CNT_W-1:0]    bitcnt;
        logic [P_DATA_W-1:0] shift;
        logic [P_ADDR_W-1:0] ptr;
        logic [P_DATA_W-1:0] snap;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [P_DATA_W-1:0] full_byte;
    logic                done_d;
    logic [P_ADDR_W-1:0] rd_addr_d;
    logic                miso_d, miso_q;

    assign full_byte = {fsm_q.shift[P_DATA_W-2:0], mosi};

    always_comb begin
        fsm_d       = fsm_q;
        done_d      = 1'b0;
        rd_addr_d   = fsm_q.ptr;
        fsm_d.shift = full_byte;
        case (fsm_q.state)
            ST_IDLE: begin
                fsm_d.wr     = mosi;
                fsm_d.bitcnt = fsm_q.bitcnt - 1'b1;
                fsm_d.state  = ST_CMD;
            end
            ST_CMD: begin
                if (fsm_q.bitcnt == '0) begin
                    fsm_d.ptr    = full_byte[P_ADDR_W-1:0];
                    fsm_d.bitcnt = CNT_TOP;
                    fsm_d.state  = ST_BURST;
                    rd_addr_d    = full_byte[P_ADDR_W-1:0];
                    fsm_d.snap   = rd_data_i;
                end else begin
                    fsm_d.bitcnt = fsm_q.bitcnt - 1'b1;
                end
            end
            ST_BURST: begin
                if (fsm_q.bitcnt == '0) begin
                    done_d       = 1'b1;
                    fsm_d.ptr    = (fsm_q.ptr >= PTR_LAST) ? '0 : fsm_q.ptr + 1'b1;
                    fsm_d.bitcnt = CNT_TOP;
                    rd_addr_d    = fsm_d.ptr;
                    fsm_d.snap   = rd_data_i;
                end else begin
                    fsm_d.bitcnt = fsm_q.bitcnt - 1'b1;
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge sclk or negedge arst_n) begin
        if (!arst_n) begin
            fsm_q.state  <= ST_IDLE;
            fsm_q.wr     <= 1'b0;
            fsm_q.bitcnt <= CNT_TOP;
            fsm_q.shift  <= '0;
            fsm_q.ptr    <= '0;
            fsm_q.snap   <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    // read data launched on the falling edge, MSB first
    always_comb begin
        miso_d = (fsm_q.state == ST_BURST) ? fsm_q.snap[fsm_q.bitcnt] : 1'b0;
    end

    always_ff @(negedge sclk or negedge arst_n) begin
        if (!arst_n) miso_q <= 1'b0;
        else         miso_q <= miso_d;
    end

    assign rd_addr_o   = rd_addr_d;
    assign miso_o      = miso_q;
    assign byte_done_o = done_d;
    assign byte_o      = full_byte;
    assign wr_o        = fsm_q.wr;
    assign ptr_o       = fsm_q.ptr;

    AST_PTR_WRAP: assert property (@(posedge sclk) disable iff (!arst_n)
        (done_d && fsm_q.ptr == PTR_LAST) |=> (fsm_q.ptr == '0)); // R4

    AST_BURST_HOLDS_MODE: assert property (@(posedge sclk) disable iff (!arst_n)
        (fsm_q.state == ST_BURST) |=> (fsm_q.state == ST_BURST && $stable(fsm_q.wr))); // R2

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_burst_pkg::*;
#(
    parameter int unsigned P_DATA_W   = DATA_W,
    parameter int unsigned P_ADDR_W   = ADDR_W,
    parameter int unsigned P_NUM_REGS = NUM_REGS
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [P_ADDR_W-1:0] wr_addr,
    input  logic [P_DATA_W-1:0] wr_data,
    input  logic [P_ADDR_W-1:0] rd_addr,
    output logic [P_DATA_W-1:0] rd_data
);

    localparam logic [P_ADDR_W-1:0] TOP_ADDR = P_ADDR_W'(P_NUM_REGS - 1);

    logic [P_DATA_W-1:0] bank_d [P_NUM_REGS];
    logic [P_DATA_W-1:0] bank_q [P_NUM_REGS];

    always_comb begin
        for (int i = 0; i < int'(P_NUM_REGS); i++) begin
            bank_d[i] = bank_q[i];
        end
        if (wr_en && wr_addr <= TOP_ADDR) begin
            bank_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(P_NUM_REGS); i++) bank_q[i] <= '0;
        end else begin
            for (int i = 0; i < int'(P_NUM_REGS); i++) bank_q[i] <= bank_d[i];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr <= TOP_ADDR) rd_data = bank_q[rd_addr];
    end

endmodule

// File: rtl/spi_side_strobes.sv
module spi_side_strobes
    import spi_burst_pkg::*;
#(
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_ADDR_W = ADDR_W
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                byte_done,
    input  logic                wr,
    input  logic [P_ADDR_W-1:0] ptr,
    input  logic [P_DATA_W-1:0] data,
    input  logic                rx_nonempty,
    output logic                abort_o,
    output logic                push_o,
    output logic [P_DATA_W-1:0] push_data_o,
    output logic                pop_o
);

    localparam logic [P_ADDR_W-1:0] CFG_HI = P_ADDR_W'(ADDR_CFG_HI);
    localparam logic [P_ADDR_W-1:0] DLO    = P_ADDR_W'(ADDR_DLO);

    typedef struct packed {
        logic                abort;
        logic                push;
        logic                pop;
        logic [P_DATA_W-1:0] data;
    } strb_t;

    strb_t strb_d, strb_q;

    always_comb begin
        strb_d       = strb_q;
        strb_d.abort = 1'b0;
        strb_d.push  = 1'b0;
        strb_d.pop   = 1'b0;
        if (byte_done) begin
            strb_d.abort = wr && (ptr <= CFG_HI);
            strb_d.push  = wr && (ptr == DLO);
            strb_d.pop   = (ptr == DLO) && rx_nonempty;
            if (wr && ptr == DLO) strb_d.data = data;
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) strb_q <= '0;
        else        strb_q <= strb_d;
    end

    assign abort_o     = strb_q.abort;
    assign push_o      = strb_q.push;
    assign pop_o       = strb_q.pop;
    assign push_data_o = strb_q.data;

    AST_ABORT_ONE_CYCLE: assert property (@(posedge sclk) disable iff (!rst_n)
        strb_q.abort |=> !strb_q.abort); // R6

    AST_PUSH_ONE_CYCLE: assert property (@(posedge sclk) disable iff (!rst_n)
        strb_q.push |=> !strb_q.push); // R7

    AST_NO_ABORT_WITH_PUSH: assert property (@(posedge sclk) disable iff (!rst_n)
        !(strb_q.abort && strb_q.push)); // R6

    AST_POP_NEEDS_DATA: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(strb_q.pop) |-> $past(rx_nonempty)); // R8

endmodule

// File: rtl/spi_burst_regs.sv
module spi_burst_regs
    import spi_burst_pkg::*;
(
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              rx_fifo_nonempty,
    output logic              miso,
    output logic              abort_req,
    output logic              tx_fifo_push,
    output logic [DATA_W-1:0] tx_fifo_data,
    output logic              rx_fifo_pop
);

    logic              arst_n;
    logic              byte_done;
    logic              wr_flag;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] rx_byte;

    assign arst_n = rst_n & ~cs_n;

    spi_burst_fsm #(
        .P_DATA_W(DATA_W), .P_ADDR_W(ADDR_W), .P_NUM_REGS(NUM_REGS)
    ) u_fsm (
        .sclk(sclk), .arst_n(arst_n), .mosi(mosi),
        .rd_data_i(rd_data), .rd_addr_o(rd_addr), .miso_o(miso),
        .byte_done_o(byte_done), .byte_o(rx_byte), .wr_o(wr_flag), .ptr_o(ptr)
    );

    spi_reg_bank #(
        .P_DATA_W(DATA_W), .P_ADDR_W(ADDR_W), .P_NUM_REGS(NUM_REGS)
    ) u_bank (
        .sclk(sclk), .rst_n(rst_n), .wr_en(byte_done && wr_flag),
        .wr_addr(ptr), .wr_data(rx_byte), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    spi_side_strobes #(
        .P_DATA_W(DATA_W), .P_ADDR_W(ADDR_W)
    ) u_strb (
        .sclk(sclk), .rst_n(rst_n), .byte_done(byte_done), .wr(wr_flag),
        .ptr(ptr), .data(rx_byte), .rx_nonempty(rx_fifo_nonempty),
        .abort_o(abort_req), .push_o(tx_fifo_push),
        .push_data_o(tx_fifo_data), .pop_o(rx_fifo_pop)
    );

endmodule

// File: tb/spi_burst_regs_test.sv
module spi_burst_regs_test;

    logic       sclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       rx_ne = 1'b0;
    logic       miso;
    logic       abort_req, tx_fifo_push, rx_fifo_pop;
    logic [7:0] tx_fifo_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] mdl [22];
    logic [7:0] txb [64];
    logic [7:0] exp_q [$];
    bit         miso_moved;

    always #4 sclk = ~sclk;

    spi_burst_regs uut (
        .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .mosi(mosi),
        .rx_fifo_nonempty(rx_ne), .miso(miso), .abort_req(abort_req),
        .tx_fifo_push(tx_fifo_push), .tx_fifo_data(tx_fifo_data),
        .rx_fifo_pop(rx_fifo_pop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
        logic a, b;
        for (int i = 7; i >= 0; i--) begin
            @(negedge sclk);
            cs_n = 1'b0;
            mosi = tx[i];
            @(posedge sclk);
            #1 a = miso;
            #2 b = miso;            // still before the next falling edge
            if (a !== b) miso_moved = 1;
            rx[i] = a;
        end
    endtask

    // monitor: compares each received byte with the scoreboard head
    task automatic monitor_cmp(input logic [7:0] rx);
        logic [7:0] e;
        e = exp_q.pop_front();
        chk("R5/R9 read byte", {24'd0, rx}, {24'd0, e});
    endtask

    task automatic end_cs();
        @(negedge sclk);
        cs_n = 1'b1;
        mosi = 1'b0;
        @(posedge sclk);
        #1 chk("R1 strobes clear", {29'd0, abort_req, tx_fifo_push, rx_fifo_pop}, 32'd0);
    endtask

    task automatic burst(input bit wr, input int start, input int n, input bit rxne);
        logic [7:0] rx;
        int cur;
        int addr;
        rx_ne = rxne;
        miso_moved = 0;
        xfer_byte({wr, 2'b00, 5'(start)}, rx);
        cur = start;
        for (int k = 0; k < n; k++) begin
            addr = cur;
            exp_q.push_back((addr < 22) ? mdl[addr] : 8'h00);
            xfer_byte(txb[k], rx);
            chk("R6 abort", {31'd0, abort_req}, {31'd0, wr && addr <= 4});
            chk("R7 push",  {31'd0, tx_fifo_push}, {31'd0, wr && addr == 5});
            chk("R8 pop",   {31'd0, rx_fifo_pop}, {31'd0, addr == 5 && rxne});
            if (wr && addr == 5) chk("R7 push data", {24'd0, tx_fifo_data}, {24'd0, txb[k]});
            monitor_cmp(rx);
            if (wr && addr < 22) mdl[addr] = txb[k];
            cur = (cur >= 21) ? 0 : cur + 1;
        end
        chk("R9 miso stable between falling edges", {31'd0, miso_moved}, 32'd0);
        end_cs();
    endtask

    task automatic fill(input int seed);
        for (int k = 0; k < 64; k++) txb[k] = 8'((k * 37 + seed * 11 + 5) ^ 8'hA5);
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        for (int i = 0; i < 22; i++) mdl[i] = 8'h00;
        repeat (4) @(posedge sclk);
        #1 chk("R1 reset miso", {31'd0, miso}, 32'd0);
        chk("R1 reset strobes", {29'd0, abort_req, tx_fifo_push, rx_fifo_pop}, 32'd0);
        @(negedge sclk) rst_n = 1'b1;

        // R1 R3 R4 R8: read the whole reset bank, pop at data-low
        fill(1);
        burst(1'b0, 0, 22, 1'b1);

        // R4 R6 R5: write across the wrap, aborts land after it
        fill(2);
        burst(1'b1, 7, 20, 1'b0);

        // R7 R8: write data-low with empty receive FIFO
        fill(3);
        burst(1'b1, 5, 2, 1'b0);

        // R2 R3 R4: read everything back across the wrap, no writes
        fill(4);
        burst(1'b0, 3, 25, 1'b1);

        // R5: write-and-read returns prior contents
        fill(5);
        burst(1'b1, 20, 3, 1'b1);

        // R11: start beyond the bank, then jump to 0
        fill(6);
        burst(1'b1, 25, 3, 1'b0);
        fill(7);
        burst(1'b0, 22, 3, 1'b0);

        // R10: chip select dropped four bits into a data-low write
        xfer_byte({1'b1, 2'b00, 5'd5}, rx);
        for (int i = 0; i < 4; i++) begin
            @(negedge sclk);
            mosi = ~mosi;
            @(posedge sclk);
        end
        end_cs();
        #1 chk("R10 no push after partial byte", {31'd0, tx_fifo_push}, 32'd0);
        chk("R10 no abort after partial byte", {31'd0, abort_req}, 32'd0);
        fill(8);
        burst(1'b0, 5, 1, 1'b0);   // R10 data-low unchanged

        // R10: command only, no strobes
        xfer_byte({1'b1, 2'b00, 5'd0}, rx);
        #1 chk("R10 command-only abort", {31'd0, abort_req}, 32'd0);
        end_cs();
        fill(9);
        burst(1'b0, 0, 1, 1'b0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule